// File: doc/BRIEF.md
# Indexed Set/Clear Interrupt Mask Controller

This block arbitrates among 64 raw interrupt request lines. Each source has two pieces of state. The first is a mask bit. The second is a byte-wide control register whose low three bits give the source's priority level. On every clock the block selects, from the sources that are pending, unmasked and have a non-zero level, the one with the highest level. When several sources share that level, the lowest-numbered one wins. The block presents the winner's number and level on registered outputs.

Software never rewrites the full 64-bit mask. It writes a source number to a byte-wide "mask one" port or to an "unmask one" port, and the byte value 0xFF on either port acts on every source at once. The mask can be read back as eight bytes. All access goes through a simple byte register bus: an address, a write strobe and write data, with read data registered on every cycle.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After a synchronous reset every source is masked, every control register reads 0x00 and `irq_valid`, `irq_level` and `irq_src` are 0.
- R2: Writing a value n in 0..63 to the mask-one port at address 0x48 sets mask bit n and leaves the other 63 mask bits unchanged.
- R3: Writing a value n in 0..63 to the unmask-one port at address 0x49 clears mask bit n and leaves the other 63 mask bits unchanged.
- R4: Writing 0xFF to address 0x48 masks all 64 sources in one write.
- R5: Writing 0xFF to address 0x49 unmasks all 64 sources in one write.
- R6: Writing any value from 64 to 254 to address 0x48 or 0x49 leaves the whole mask unchanged.
- R7: The control register of source n sits at address n (0x00..0x3F), is read/write and keeps all 8 bits. Bits [2:0] are the source's level. A source whose level is 0 never produces a request.
- R8: `irq_valid` is 1 when at least one source is pending, unmasked and has a non-zero level. `irq_level` then gives the highest such level and `irq_src` gives the lowest-numbered source at that level. When `irq_valid` is 0, both fields are 0.
- R9: The request outputs are registered: they reflect `irq_in`, the mask and the levels as they stood before the previous rising clock edge.
- R10: Address 0x40+k reads mask byte k, whose bit i is the mask of source 8k+i (1 means masked). `bus_rdata` is registered from the address present at the previous edge, shows the state before any write at that edge, and is 0x00 for the two write-only ports and for unused addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Raw request lines, bit n is source n |
| bus_addr | input | 8 | Register bus byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_valid | output | 1 | A request is being presented |
| irq_level | output | 3 | Level of the presented request |
| irq_src | output | 6 | Number of the presented source |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk` and that the bus inputs are free of X on every edge, so that a write strobe always sees a defined address and data. One write per cycle is built into the bus, which means the set and clear ports are never hit together. The bench drives every input on the falling edge from a single process, so each of these assumptions holds. It mixes directed writes of in-range indices, of 0xFF and of out-of-range indices with randomized traffic, and compares against a behavioural model on every cycle.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  // Register bus map; the mask byte window must start on an 8-byte boundary
  localparam logic [7:0] CTRL_BASE = 8'h00;
  localparam logic [7:0] MASK_BASE = 8'h40;
  localparam logic [7:0] SET_PORT  = 8'h48;
  localparam logic [7:0] CLR_PORT  = 8'h49;
  localparam logic [7:0] ALL_CODE  = 8'hFF;

  typedef enum logic [1:0] {
    RG_CTRL,
    RG_MASK,
    RG_NONE
  } region_e;
endpackage

// File: rtl/irqm_mask_bank.sv
module irqm_mask_bank #(
  parameter int N     = 64,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  mask_q
);
  localparam logic [DW-1:0] ALL = '1;
  localparam logic [DW-1:0] N_V = DW'(N);

  logic idx_ok;
  assign idx_ok = (wdata < N_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (set_we) begin
      if (wdata == ALL) mask_q <= '1;
      else if (idx_ok)  mask_q[wdata[IDX_W-1:0]] <= 1'b1;
    end else if (clr_we) begin
      if (wdata == ALL) mask_q <= '0;
      else if (idx_ok)  mask_q[wdata[IDX_W-1:0]] <= 1'b0;
    end
  end

  p_set_one_r2: assert property (@(posedge clk) disable iff (rst)
    (set_we && wdata < N_V) |=> mask_q[$past(wdata[IDX_W-1:0])]);
  p_set_count_r2: assert property (@(posedge clk) disable iff (rst)
    (set_we && wdata < N_V) |=> ($countones(mask_q) <= $countones($past(mask_q)) + 1));
  p_clr_one_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_we && wdata < N_V) |=> !mask_q[$past(wdata[IDX_W-1:0])]);
  p_set_all_r4: assert property (@(posedge clk) disable iff (rst)
    (set_we && wdata == ALL) |=> (&mask_q));
  p_clr_all_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_we && wdata == ALL) |=> (mask_q == '0));
  p_ignore_idx_r6: assert property (@(posedge clk) disable iff (rst)
    ((set_we || clr_we) && wdata >= N_V && wdata != ALL) |=> $stable(mask_q));
  p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irqm_level_bank.sv
module irqm_level_bank #(
  parameter int N     = 64,
  parameter int DW    = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rd_byte,
  output logic [N*LVL_W-1:0] levels
);
  logic [DW-1:0] ctrl_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ctrl_q[i] <= '0;
    end else if (we) begin
      ctrl_q[idx] <= wdata;
    end
  end

  assign rd_byte = ctrl_q[idx];

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign levels[g*LVL_W +: LVL_W] = ctrl_q[g][LVL_W-1:0];
  end

  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> (ctrl_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/irqm_arbiter.sv
module irqm_arbiter #(
  parameter int N     = 64,
  parameter int LVL_W = 3,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       pend,
  input  logic [N-1:0]       mask,
  input  logic [N*LVL_W-1:0] levels,
  output logic               any,
  output logic [LVL_W-1:0]   best_lvl,
  output logic [IDX_W-1:0]   best_idx
);
  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    logic [LVL_W-1:0] lv;
    any      = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      lv = levels[i*LVL_W +: LVL_W];
      if (pend[i] && !mask[i] && (lv != '0) && (lv >= best_lvl)) begin
        any      = 1'b1;
        best_lvl = lv;
        best_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any) assert (best_lvl != '0) else $error("p_win_level_r7");
    if (!any) assert (best_idx == '0) else $error("p_idle_index_r8");
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqm_pkg::*;
#(
  parameter int N     = 64,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_valid,
  output logic [LVL_W-1:0] irq_level,
  output logic [IDX_W-1:0] irq_src
);
  localparam int MB  = N / 8;
  localparam int MBW = (MB > 1) ? $clog2(MB) : 1;

  region_e          region;
  logic             set_we, clr_we, ctrl_we;
  logic [N-1:0]     mask_q;
  logic [MB-1:0][7:0] mask_bytes;
  logic [DW-1:0]    ctrl_byte;
  logic [N*LVL_W-1:0] levels;
  logic             win_any;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    if (bus_addr < AW'(N) + CTRL_BASE)
      region = RG_CTRL;
    else if (bus_addr >= MASK_BASE && bus_addr < MASK_BASE + AW'(MB))
      region = RG_MASK;
    else
      region = RG_NONE;
  end

  assign set_we  = bus_we && (bus_addr == SET_PORT);
  assign clr_we  = bus_we && (bus_addr == CLR_PORT);
  assign ctrl_we = bus_we && (region == RG_CTRL);

  irqm_mask_bank #(.N(N), .DW(DW), .IDX_W(IDX_W)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_we (set_we),
    .clr_we (clr_we),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  irqm_level_bank #(.N(N), .DW(DW), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .idx     (bus_addr[IDX_W-1:0]),
    .wdata   (bus_wdata),
    .rd_byte (ctrl_byte),
    .levels  (levels)
  );

  irqm_arbiter #(.N(N), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .pend     (irq_in),
    .mask     (mask_q),
    .levels   (levels),
    .any      (win_any),
    .best_lvl (win_lvl),
    .best_idx (win_idx)
  );

  assign mask_bytes = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      unique case (region)
        RG_CTRL: bus_rdata <= ctrl_byte;
        RG_MASK: bus_rdata <= DW'(mask_bytes[bus_addr[MBW-1:0]]);
        default: bus_rdata <= '0;
      endcase
      irq_valid <= win_any;
      irq_level <= win_lvl;
      irq_src   <= win_idx;
    end
  end

  p_level_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_level != '0));
  p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_valid);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_level == '0 && irq_src == '0));
  p_winner_pending_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (($past(irq_in) >> irq_src) & N'(1)) == N'(1));
  p_winner_unmasked_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (($past(mask_q) >> irq_src) & N'(1)) == '0);
  p_port_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == SET_PORT || bus_addr == CLR_PORT) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_valid;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  bit       m_mask [64];
  int       m_ctrl [64];
  int       e_valid, e_lvl, e_src, e_rdata;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      foreach (m_mask[i]) begin m_mask[i] = 1; m_ctrl[i] = 0; end
      e_valid = 0; e_lvl = 0; e_src = 0; e_rdata = 0;
    end else begin
      int bl, bs, bv, a, d;
      bl = 0; bs = 0; bv = 0;
      for (int i = 0; i < 64; i++) begin
        if (irq_in[i] && !m_mask[i] && (m_ctrl[i] % 8) > bl) begin
          bl = m_ctrl[i] % 8; bs = i; bv = 1;
        end
      end
      e_valid = bv; e_lvl = bl; e_src = bs;
      a = bus_addr; d = bus_wdata;
      if (a < 64) e_rdata = m_ctrl[a];
      else if (a >= 64 && a < 72) begin
        e_rdata = 0;
        for (int b = 0; b < 8; b++) if (m_mask[(a - 64) * 8 + b]) e_rdata += (1 << b);
      end else e_rdata = 0;
      if (bus_we) begin
        if (a < 64) m_ctrl[a] = d;
        else if (a == 72 || a == 73) begin
          if (d == 255) foreach (m_mask[i]) m_mask[i] = (a == 72);
          else if (d < 64) m_mask[d] = (a == 72);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R8 R9 irq_valid", int'(irq_valid), e_valid);
      check("R8 R9 irq_level", int'(irq_level), e_lvl);
      check("R8 R9 irq_src", int'(irq_src), e_src);
      check("R7 R10 bus_rdata", int'(bus_rdata), e_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    bus_addr = 8'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 8'(a); bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_valid", int'(irq_valid), 0);
    for (int k = 0; k < 8; k++) begin rd(64 + k, v); check("R1 mask byte", v, 8'hFF); end
    rd(0, v);  check("R1 ctrl 0", v, 0);
    rd(63, v); check("R1 ctrl 63", v, 0);
    // levels: source i gets level i%8
    for (int i = 0; i < 64; i++) wr(i, i % 8);
    wr(20, 8'hFD);
    rd(20, v); check("R7 ctrl keeps 8 bits", v, 8'hFD);
    irq_in = '1;
    repeat (2) @(negedge clk);
    check("R1 all masked quiet", int'(irq_valid), 0);
    // R3 unmask one
    wr(73, 10);
    rd(65, v); check("R3 byte1 after unmask 10", v, 8'hFB);
    check("R8 single source", int'(irq_src), 10);
    wr(73, 13); wr(73, 21);
    @(negedge clk);
    check("R8 highest level wins", int'(irq_src), 13);
    check("R8 highest level value", int'(irq_level), 5);
    wr(73, 7);
    @(negedge clk);
    check("R8 level 7 source", int'(irq_src), 7);
    // R2 mask one
    wr(72, 7);
    rd(64, v); check("R2 byte0 after mask 7", v, 8'hFF);
    rd(65, v); check("R2 byte1 untouched", v, 8'hDB);
    check("R8 back to 13", int'(irq_src), 13);
    // R6 out-of-range indices
    wr(72, 64); wr(72, 200); wr(73, 254); wr(73, 100); wr(73, 64);
    rd(65, v); check("R6 byte1 stable", v, 8'hDB);
    rd(66, v); check("R6 byte2 stable", v, 8'hDF);
    rd(71, v); check("R6 byte7 stable", v, 8'hFF);
    // R7 level zero never requests
    wr(72, 255); wr(73, 16);
    rd(66, v); check("R7 byte2 only 16 open", v, 8'hFE);
    check("R7 level 0 silent", int'(irq_valid), 0);
    // R5 unmask all
    wr(73, 255);
    for (int k = 0; k < 8; k++) begin rd(64 + k, v); check("R5 mask byte", v, 0); end
    check("R5 R8 src", int'(irq_src), 7);
    check("R5 R8 level", int'(irq_level), 7);
    // R4 mask all
    wr(72, 255);
    for (int k = 0; k < 8; k++) begin rd(64 + k, v); check("R4 mask byte", v, 8'hFF); end
    check("R4 quiet", int'(irq_valid), 0);
    // R9 latency
    wr(73, 255); irq_in = '0;
    repeat (2) @(negedge clk);
    irq_in[30] = 1'b1;
    #1 check("R9 no change before edge", int'(irq_valid), 0);
    @(negedge clk);
    check("R9 valid one edge later", int'(irq_valid), 1);
    check("R9 src", int'(irq_src), 30);
    check("R9 level", int'(irq_level), 6);
    // R8 tie: sources 3, 11, 19 at level 3
    irq_in = '0; irq_in[19] = 1; irq_in[11] = 1; irq_in[3] = 1;
    @(negedge clk);
    check("R8 tie lowest index", int'(irq_src), 3);
    // R10 write-only ports read zero
    rd(72, v); check("R10 set port reads 0", v, 0);
    rd(73, v); check("R10 clr port reads 0", v, 0);
    rd(80, v); check("R10 unused reads 0", v, 0);
    // randomized traffic checked against the model each cycle
    for (int c = 0; c < 4000; c++) begin
      int op, x;
      op = $urandom_range(0, 9);
      x  = $urandom_range(0, 255);
      if ($urandom_range(0, 3) == 0) irq_in = {$urandom, $urandom};
      if (op < 2)      begin bus_addr = 8'($urandom_range(0, 63)); bus_wdata = 8'(x); bus_we = 1; end
      else if (op < 4) begin bus_addr = 8'd72; bus_we = 1;
                             bus_wdata = (x < 20) ? 8'hFF : 8'($urandom_range(0, 90)); end
      else if (op < 7) begin bus_addr = 8'd73; bus_we = 1;
                             bus_wdata = (x < 10) ? 8'hFF : 8'($urandom_range(0, 90)); end
      else             begin bus_addr = 8'($urandom_range(0, 80)); bus_we = 0; end
      @(negedge clk);
      bus_we = 0;
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule